// File: doc/BRIEF.md
# Prioritized Interrupt Identification Unit

This block sits beside a serial port's register file. It gathers five interrupt conditions from the surrounding logic and ranks them: a line error or break, receive data at the trigger level, receive character time-out, transmit holding register empty, and modem status change. It then presents a one-byte identification value that the host reads at a fixed register address. It also drives an interrupt request line to the interrupt controller. The line error, time-out, transmit-empty and modem conditions arrive as one-cycle set pulses. The block latches each of them until its own clear strobe arrives. The receive-trigger condition is a level that follows the FIFO fill state directly.

A host read of the identification register is a run of consecutive cycles with the read strobe high and the register's address on the bus. For the whole run, the value captured in the first cycle of the run stays on the identification bus. Events that arrive during the run are still latched, and they show up once the run ends. If the value the host read named the transmit-empty source, that source is acknowledged when the run ends. A per-source enable masks each class before it is ranked and before it can raise the request line.

Top module: `irq_ident`

## Requirements
- R1: `iir_o[0]` is active low: 0 when at least one enabled source is pending and 1 otherwise. `irq_o` is high exactly when an enabled source is pending, and it follows the live state even while a read is in progress.
- R2: `iir_o[3:1]` names the highest-ranked enabled pending source. The ranks, highest first, are line error 3'b011, RX time-out 3'b110, RX trigger 3'b010, TX empty 3'b001, modem 3'b000. With nothing pending the field is 3'b000.
- R3: `iir_o[5:4]` always reads 2'b00. `iir_o[7:6]` reads 2'b11 when `fifo_en_i` is high and 2'b00 when it is low.
- R4: `ien_i` enables the sources: bit 0 covers both RX sources, bit 1 TX empty, bit 2 line error, bit 3 modem. A disabled source stays recorded but affects neither `iir_o` nor `irq_o`. It appears as soon as its enable is set.
- R5: A set pulse on a latched source shows on `iir_o` in the cycle after it is sampled. A set and a clear in the same cycle leave the source set.
- R6: Each latched source has its own clear: line error by `lsr_rd_i`, RX time-out by `rx_rd_i`, modem by `msr_rd_i`, TX empty by `thr_wr_i`. Each clear takes effect in the next cycle. RX trigger follows `rx_trig_i` with no latch.
- R7: A read run is consecutive cycles with `rd_i` high and `addr_i` equal to the identification address (default 2). From the second cycle of a run onward, `iir_o` repeats the byte it showed in the first cycle, including bits 7:6. Events and `fifo_en_i` changes during the run show from the first cycle after the run.
- R8: If the byte captured by a read run has bits 3:0 equal to 4'b0010 (TX empty reported), the TX-empty source is cleared when the run ends and is gone from the second cycle after the last read cycle. Otherwise TX empty is not affected by the read.
- R9: After reset no source is pending, `irq_o` is 0 and `iir_o` equals `{fifo_en_i,fifo_en_i}` followed by 6'b000001.
- R10: A read at any other address neither holds `iir_o` nor acknowledges TX empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode is enabled |
| ien_i | input | 4 | Per-class enables: RX, TX empty, line error, modem |
| line_err_set_i | input | 1 | Pulse: line error or break detected |
| lsr_rd_i | input | 1 | Pulse: line status read, clears line error |
| rx_trig_i | input | 1 | Level: RX FIFO at or above trigger |
| rx_tmo_set_i | input | 1 | Pulse: RX character time-out with data present |
| rx_rd_i | input | 1 | Pulse: RX FIFO read, clears time-out |
| thr_empty_set_i | input | 1 | Pulse: TX holding register became empty |
| thr_wr_i | input | 1 | Pulse: TX holding register written, clears TX empty |
| msr_chg_set_i | input | 1 | Pulse: modem status line changed |
| msr_rd_i | input | 1 | Pulse: modem status read, clears modem source |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 3 | Host register address |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a read run that has to hold its captured byte while the live ranking changes underneath it. Two things must then happen at the end of the run: the TX-empty acknowledge, based on the captured byte and not the live one, and the new events appearing. The stimulus gets there by holding a multi-cycle read. During the read it fires a higher-ranked event, toggles FIFO mode and pulses a TX set. A run that begins with TX empty reported is contrasted with one that begins with a line error reported. Set-and-clear collisions and masked sources that are re-enabled later complete the corners.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
  localparam int unsigned NUM_RANK = 5;
  // ranked slot index: higher index wins
  localparam int unsigned K_MDM  = 0;
  localparam int unsigned K_TX   = 1;
  localparam int unsigned K_TRIG = 2;
  localparam int unsigned K_TMO  = 3;
  localparam int unsigned K_LINE = 4;

  // latched source index
  localparam int unsigned NUM_LAT = 4;
  localparam int unsigned L_LINE  = 0;
  localparam int unsigned L_TMO   = 1;
  localparam int unsigned L_TX    = 2;
  localparam int unsigned L_MDM   = 3;

  typedef enum logic [2:0] {
    ID_NONE_MDM = 3'b000,
    ID_TX       = 3'b001,
    ID_TRIG     = 3'b010,
    ID_LINE     = 3'b011,
    ID_TMO      = 3'b110
  } src_id_e;

  function automatic src_id_e id_of(input int unsigned k);
    case (k)
      K_LINE:  return ID_LINE;
      K_TMO:   return ID_TMO;
      K_TRIG:  return ID_TRIG;
      K_TX:    return ID_TX;
      default: return ID_NONE_MDM;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end

    p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ident_pkg::*;
(
  input  logic [NUM_RANK-1:0] pend_i,
  output logic [2:0]          id_o,
  output logic                none_o
);
  always_comb begin
    id_o = ID_NONE_MDM;
    for (int unsigned k = 0; k < NUM_RANK; k++)
      if (pend_i[k]) id_o = id_of(k);
    none_o = ~|pend_i;
  end

  always_comb begin
    if (pend_i[K_LINE]) p_line_top_r2: assert (id_o == ID_LINE);
    if (!pend_i[K_LINE] && pend_i[K_TMO]) p_tmo_over_trig_r2: assert (id_o == ID_TMO);
  end
endmodule

// File: rtl/iir_freeze.sv
module iir_freeze #(
  parameter int unsigned AW       = 3,
  parameter int unsigned DW       = 8,
  parameter int unsigned IIR_ADDR = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] live_i,
  output logic [DW-1:0] iir_o,
  output logic          frozen_o,
  output logic          tx_ack_o
);
  localparam logic [AW-1:0] HIT_ADDR = AW'(IIR_ADDR);
  localparam logic [3:0]    TX_LOW   = 4'b0010;
  localparam logic [DW-1:0] RST_VAL  = DW'(1);

  logic          hit, hit_q;
  logic [DW-1:0] frz_q;

  assign hit = rd_i && (addr_i == HIT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      frz_q <= RST_VAL;
    end else begin
      hit_q <= hit;
      if (hit && !hit_q) frz_q <= live_i;
    end
  end

  assign frozen_o = hit && hit_q;
  assign iir_o    = frozen_o ? frz_q : live_i;
  // acknowledge on the cycle the run ends, judged on what the host saw
  assign tx_ack_o = hit_q && !hit && (frz_q[3:0] == TX_LOW);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> $stable(iir_o));
  p_ack_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_o |-> $past(hit));
endmodule

// File: rtl/irq_ident.sv
module irq_ident
  import irq_ident_pkg::*;
#(
  parameter int unsigned AW       = 3,
  parameter int unsigned IIR_ADDR = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic [3:0]    ien_i,
  input  logic          line_err_set_i,
  input  logic          lsr_rd_i,
  input  logic          rx_trig_i,
  input  logic          rx_tmo_set_i,
  input  logic          rx_rd_i,
  input  logic          thr_empty_set_i,
  input  logic          thr_wr_i,
  input  logic          msr_chg_set_i,
  input  logic          msr_rd_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    iir_o,
  output logic          irq_o
);
  localparam int unsigned EN_RX = 0;
  localparam int unsigned EN_TX = 1;
  localparam int unsigned EN_LN = 2;
  localparam int unsigned EN_MD = 3;

  logic [NUM_LAT-1:0]  lat_set, lat_clr, lat_q;
  logic [NUM_RANK-1:0] pend;
  logic [2:0]          id;
  logic                none, frozen, tx_ack;
  logic [7:0]          live;

  always_comb begin
    lat_set        = '0;
    lat_clr        = '0;
    lat_set[L_LINE] = line_err_set_i;
    lat_clr[L_LINE] = lsr_rd_i;
    lat_set[L_TMO]  = rx_tmo_set_i;
    lat_clr[L_TMO]  = rx_rd_i;
    lat_set[L_TX]   = thr_empty_set_i;
    lat_clr[L_TX]   = thr_wr_i | tx_ack;
    lat_set[L_MDM]  = msr_chg_set_i;
    lat_clr[L_MDM]  = msr_rd_i;
  end

  irq_src_latch #(.N(NUM_LAT)) i_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (lat_set),
    .clr_i (lat_clr),
    .q_o   (lat_q)
  );

  always_comb begin
    pend         = '0;
    pend[K_LINE] = lat_q[L_LINE] & ien_i[EN_LN];
    pend[K_TMO]  = lat_q[L_TMO]  & ien_i[EN_RX];
    pend[K_TRIG] = rx_trig_i     & ien_i[EN_RX];
    pend[K_TX]   = lat_q[L_TX]   & ien_i[EN_TX];
    pend[K_MDM]  = lat_q[L_MDM]  & ien_i[EN_MD];
  end

  irq_prio_enc i_enc (
    .pend_i(pend),
    .id_o  (id),
    .none_o(none)
  );

  assign live  = {{2{fifo_en_i}}, 2'b00, id, none};
  assign irq_o = ~none;

  iir_freeze #(.AW(AW), .DW(8), .IIR_ADDR(IIR_ADDR)) i_frz (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .live_i  (live),
    .iir_o   (iir_o),
    .frozen_o(frozen),
    .tx_ack_o(tx_ack)
  );

  p_irq_vs_pend_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen |-> (irq_o == !iir_o[0]));
  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5:4] == 2'b00);
  p_fifo_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7] == iir_o[6]);
  p_tx_acked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ack && !thr_empty_set_i) |=> !lat_q[L_TX]);
endmodule

// File: tb/test_irq_ident.sv
`timescale 1ns/1ps
module test_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [3:0] ien = 4'h0;
  logic       ln_set = 0, lsr_rd = 0, trig = 0, tmo_set = 0, rx_rd = 0;
  logic       tx_set = 0, thr_wr = 0, md_set = 0, msr_rd = 0, rd = 0;
  logic [2:0] addr = 3'd0;
  logic [7:0] iir;
  logic       irq;

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";

  // reference state
  bit m_ln, m_tmo, m_tx, m_md, m_rdq;
  logic [7:0] m_frz = 8'h01;

  always #2.5 clk = ~clk;

  irq_ident i_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .ien_i(ien),
    .line_err_set_i(ln_set), .lsr_rd_i(lsr_rd), .rx_trig_i(trig),
    .rx_tmo_set_i(tmo_set), .rx_rd_i(rx_rd), .thr_empty_set_i(tx_set),
    .thr_wr_i(thr_wr), .msr_chg_set_i(md_set), .msr_rd_i(msr_rd),
    .rd_i(rd), .addr_i(addr), .iir_o(iir), .irq_o(irq)
  );

  function automatic logic [7:0] live_exp();
    logic [2:0] id = 3'b000;
    bit p = 1'b1;
    if (m_md && ien[3])       begin id = 3'b000; p = 0; end
    if (m_tx && ien[1])       begin id = 3'b001; p = 0; end
    if (trig && ien[0])       begin id = 3'b010; p = 0; end
    if (m_tmo && ien[0])      begin id = 3'b110; p = 0; end
    if (m_ln && ien[2])       begin id = 3'b011; p = 0; end
    return {fifo_en, fifo_en, 2'b00, id, p};
  endfunction

  function automatic bit hit();
    return rd && addr == 3'd2;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [7:0] l;
    bit ack;
    #1;
    l = live_exp();
    chk({cur_req, " iir"}, iir, (hit() && m_rdq) ? m_frz : l);
    chk({cur_req, " R1 irq"}, {7'd0, irq}, {7'd0, ~l[0]});
    @(posedge clk);
    ack = m_rdq && !hit() && (m_frz[3:0] == 4'b0010);
    if (hit() && !m_rdq) m_frz = l;
    m_rdq = hit();
    m_ln  = ln_set  ? 1'b1 : (lsr_rd ? 1'b0 : m_ln);
    m_tmo = tmo_set ? 1'b1 : (rx_rd ? 1'b0 : m_tmo);
    m_tx  = tx_set  ? 1'b1 : ((thr_wr || ack) ? 1'b0 : m_tx);
    m_md  = md_set  ? 1'b1 : (msr_rd ? 1'b0 : m_md);
    @(negedge clk);
  endtask

  task automatic idle();
    {ln_set, lsr_rd, tmo_set, rx_rd, tx_set, thr_wr, md_set, msr_rd} = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      idle();
    end
  endtask

  task automatic read_run(input int n, input logic [2:0] a);
    addr = a; rd = 1'b1;
    step(n);
    rd = 1'b0; addr = 3'd0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9 reset state
    @(negedge clk);
    #1;
    chk("R9 reset iir", iir, 8'h01);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    ien = 4'hF;
    step(2);

    // R2 R5 single sources, R3 fifo bits
    cur_req = "R5";
    ln_set = 1; step(1); step(1); lsr_rd = 1; step(2);
    fifo_en = 1;
    cur_req = "R3";
    tmo_set = 1; step(2); rx_rd = 1; step(2);
    trig = 1; step(2); trig = 0; step(1);
    tx_set = 1; step(2); thr_wr = 1; step(2);
    md_set = 1; step(2); msr_rd = 1; step(2);

    // R2 ranking combos
    cur_req = "R2";
    md_set = 1; step(1); tx_set = 1; step(1); trig = 1; step(1);
    tmo_set = 1; step(1); ln_set = 1; step(2);
    lsr_rd = 1; step(1); rx_rd = 1; step(1); trig = 0; step(1);
    thr_wr = 1; step(1); msr_rd = 1; step(2);

    // R5 set and clear collide; R6 clears
    cur_req = "R5";
    ln_set = 1; lsr_rd = 1; step(2);
    tx_set = 1; thr_wr = 1; step(2);
    cur_req = "R6";
    lsr_rd = 1; step(1); thr_wr = 1; step(1);
    md_set = 1; tmo_set = 1; step(1); rx_rd = 1; step(1); msr_rd = 1; step(2);

    // R4 masking then re-enable
    cur_req = "R4";
    ien = 4'b0000;
    ln_set = 1; tx_set = 1; md_set = 1; trig = 1; step(3);
    ien = 4'b1000; step(2);
    ien = 4'b0010; step(2);
    ien = 4'b0001; step(2);
    ien = 4'b0100; step(2);
    ien = 4'hF; lsr_rd = 1; thr_wr = 1; msr_rd = 1; trig = 0; step(2);

    // R7 hold during read with new events and fifo change
    cur_req = "R7";
    md_set = 1; step(1);
    addr = 3'd2; rd = 1;
    step(1);
    ln_set = 1; step(1);
    fifo_en = 0; step(1);
    tx_set = 1; step(2);
    rd = 0; addr = 0; step(2);
    lsr_rd = 1; msr_rd = 1; step(1); thr_wr = 1; fifo_en = 1; step(2);

    // R8 acknowledge of TX when reported
    cur_req = "R8";
    tx_set = 1; step(1);
    read_run(3, 3'd2);
    step(3);
    tx_set = 1; step(1);
    read_run(1, 3'd2);
    step(2);
    // TX not reported: line error outranks it
    tx_set = 1; ln_set = 1; step(1);
    read_run(2, 3'd2);
    step(2);
    lsr_rd = 1; step(2);
    // higher event arrives during a TX-reported read: TX still acked
    read_run(1, 3'd2);
    tx_set = 1; step(1);
    addr = 3'd2; rd = 1; step(1); md_set = 1; step(1); ln_set = 1; step(1);
    rd = 0; addr = 0; step(2);
    // new TX set on the ack cycle survives
    lsr_rd = 1; msr_rd = 1; step(1);
    tx_set = 1; step(1);
    addr = 3'd2; rd = 1; step(2);
    rd = 0; addr = 0; tx_set = 1; step(3);
    thr_wr = 1; step(1);

    // R10 other address
    cur_req = "R10";
    tx_set = 1; step(1);
    read_run(3, 3'd5);
    ln_set = 1; step(1);
    addr = 3'd3; rd = 1; step(1); lsr_rd = 1; step(2);
    rd = 0; addr = 0; step(2);
    thr_wr = 1; step(2);

    // R1 irq while frozen
    cur_req = "R1";
    addr = 3'd2; rd = 1; step(1);
    md_set = 1; step(2);
    rd = 0; addr = 0; step(1);
    msr_rd = 1; step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule